// File: doc/BRIEF.md
# Single-Slope Dual-Channel PWM Timer

This block is a 16-bit up-counting timer that drives two pulse-width modulated pins from one shared counter. The counter moves only on cycles where a tick enable from an external prescaler is high. It counts from zero up to a selectable ceiling (TOP) and then restarts at zero, so one PWM period lasts TOP+1 ticks. Each channel compares the count against its own compare value and drives its pin in a non-inverting, inverting or off style. The timer also raises sticky flags for the ceiling event and for each channel's compare event.

TOP can come from one of five sources: three fixed ceilings (8, 9 or 10 bits of ones), the channel-A compare value, or a separate capture register. The channel-A compare value is held in a shadow register. Software writes reach the shadow at once, and the live value takes the shadow only when the counter reaches TOP. The capture register has no shadow, so lowering it below the running count makes the counter run on to the all-ones value before it wraps. Software talks to the block through a simple write strobe with an address and a data word. There is no read path: the pins, the flags and the count are ports.

Register map (3-bit address): 0 = channel-A compare (shadow), 1 = channel-B compare, 2 = capture value, 3 = control, 4 = flag clear. The control word holds the TOP source in bits [2:0], the channel-A output style in bits [4:3] and the channel-B output style in bits [6:5].

Top module: `pwm_slope_timer`

## Requirements
- R1: Reset (synchronous, active high) clears the count, all compare and capture values, the flags and both pins. The control word resets to zero, which selects the 8-bit ceiling and turns both outputs off.
- R2: The count changes only on a clock edge where `tick_en` is high. On such an edge it goes up by one, unless it wraps to zero.
- R3: TOP source codes 0, 1 and 2 give ceilings of 0x00FF, 0x01FF and 0x03FF. The count wraps to zero on the tick after it reaches TOP, so a period is TOP+1 ticks. Codes 5 to 7 behave like code 0.
- R4: Output style code 1 (non-inverting) drives a pin high on the tick where the count wraps to zero and low on the tick where the count equals that channel's compare value. When both happen on the same tick, the pin goes high. Between ticks the pin holds, and it changes on the same clock edge as the count.
- R5: Output style code 2 (inverting) drives the pin low on a wrap and high on a compare match, with the wrap taking priority. Style codes 0 and 3 force the pin low on every clock.
- R6: With a compare value of zero and the non-inverting style, the pin is high for exactly one tick per period.
- R7: TOP source code 3 uses the live channel-A compare value as TOP. Pin A is then constantly high in the non-inverting style, while pin B is high for (compare B)+1 ticks of each (TOP+1)-tick period.
- R8: A write to address 0 changes only the shadow. The live channel-A compare value takes the shadow on the tick where the count equals TOP, and stays unchanged on every other clock edge.
- R9: TOP source code 4 uses the capture value, which takes effect at once. If the capture value is written below the current count, the counter keeps going up to 0xFFFF, wraps to zero, and the following period is capture+1 ticks.
- R10: The overflow flag is set on a tick where the count equals TOP, but not on a run-out wrap from 0xFFFF. A channel's compare flag is set on a tick where the count equals that channel's live compare value.
- R11: Writing to address 4 clears each flag whose bit is 1 (bit 0 overflow, bit 1 channel A, bit 2 channel B). A 0 bit leaves its flag unchanged. A set event in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Prescaled count enable, one cycle per tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address for the write |
| wr_data | input | 16 | Register write data |
| pwm_a | output | 1 | Channel A PWM pin |
| pwm_b | output | 1 | Channel B PWM pin |
| ovf_flag | output | 1 | Sticky flag for the count reaching TOP |
| cmpa_flag | output | 1 | Sticky flag for a channel-A compare match |
| cmpb_flag | output | 1 | Sticky flag for a channel-B compare match |
| count | output | 16 | Current counter value |

## Verification
Directed runs step the counter through full periods of each fixed ceiling, which separates the three ceiling widths and confirms that the wrap comes one tick after TOP. Duty measurements with a mid-range compare value, a zero compare value and a compare value equal to TOP separate the non-inverting style, the inverting style, the one-tick pulse at zero and the wrap-over-match priority. Writes to the shadow and capture registers in the middle of a period expose the difference between the deferred load and the immediate load, including the long run to 0xFFFF. A random phase then drives ticks, compare writes, style changes and flag clears against a reference model, which catches ordering faults between a write and a tick that land in the same cycle.

// File: rtl/pwm_slope_pkg.sv
package pwm_slope_pkg;

    // TOP source selection, control bits [2:0]
    typedef enum logic [2:0] {
        TOP_FIX0 = 3'd0,
        TOP_FIX1 = 3'd1,
        TOP_FIX2 = 3'd2,
        TOP_CMPA = 3'd3,
        TOP_CAPT = 3'd4
    } top_src_e;

    // Per-channel pin style
    typedef enum logic [1:0] {
        OUT_OFF    = 2'd0,
        OUT_NONINV = 2'd1,
        OUT_INV    = 2'd2,
        OUT_RSVD   = 2'd3
    } out_mode_e;

    // Control word: [6:5] style B, [4:3] style A, [2:0] TOP source
    typedef struct packed {
        out_mode_e mode_b;
        out_mode_e mode_a;
        top_src_e  top_src;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // Register addresses
    localparam int REG_CMPA   = 0;
    localparam int REG_CMPB   = 1;
    localparam int REG_CAPT   = 2;
    localparam int REG_CTRL   = 3;
    localparam int REG_FLGCLR = 4;

    // Flag bit positions
    localparam int FLAG_N   = 3;
    localparam int FLG_OVF  = 0;
    localparam int FLG_CMPA = 1;
    localparam int FLG_CMPB = 2;

    // Next pin level from style, current level, wrap and match events
    function automatic logic pin_next(out_mode_e m, logic cur, logic wrap, logic match);
        logic n;
        case (m)
            OUT_NONINV: n = wrap ? 1'b1 : (match ? 1'b0 : cur);
            OUT_INV:    n = wrap ? 1'b0 : (match ? 1'b1 : cur);
            default:    n = 1'b0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_slope_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              top_hit,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  cmpa_act,
    output logic [CNT_W-1:0]  cmpb_val,
    output logic [CNT_W-1:0]  capt_val,
    output logic [FLAG_N-1:0] flag_clr
);

    logic [CNT_W-1:0] cmpa_shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl        <= '0;
            cmpa_shadow <= '0;
            cmpa_act    <= '0;
            cmpb_val    <= '0;
            capt_val    <= '0;
        end else begin
            // deferred load of the live channel-A value at TOP
            if (top_hit) begin
                cmpa_act <= cmpa_shadow;
            end
            if (wr_en) begin
                case (wr_addr)
                    ADDR_W'(REG_CMPA): cmpa_shadow <= wr_data;
                    ADDR_W'(REG_CMPB): cmpb_val    <= wr_data;
                    ADDR_W'(REG_CAPT): capt_val    <= wr_data;
                    ADDR_W'(REG_CTRL): ctrl        <= ctrl_t'(wr_data[CTRL_W-1:0]);
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        flag_clr = '0;
        if (wr_en && wr_addr == ADDR_W'(REG_FLGCLR)) begin
            flag_clr = wr_data[FLAG_N-1:0];
        end
    end

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_slope_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int FIX_W0 = 8,
    parameter int FIX_W1 = 9,
    parameter int FIX_W2 = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  top_src_e         top_src,
    input  logic [CNT_W-1:0] cmpa_act,
    input  logic [CNT_W-1:0] capt_val,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] top_val,
    output logic             top_hit,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] CNT_ALL1 = '1;
    localparam logic [CNT_W-1:0] TOP_F0   = {{(CNT_W-FIX_W0){1'b0}}, {FIX_W0{1'b1}}};
    localparam logic [CNT_W-1:0] TOP_F1   = {{(CNT_W-FIX_W1){1'b0}}, {FIX_W1{1'b1}}};
    localparam logic [CNT_W-1:0] TOP_F2   = {{(CNT_W-FIX_W2){1'b0}}, {FIX_W2{1'b1}}};

    always_comb begin
        case (top_src)
            TOP_FIX1: top_val = TOP_F1;
            TOP_FIX2: top_val = TOP_F2;
            TOP_CMPA: top_val = cmpa_act;
            TOP_CAPT: top_val = capt_val;
            default:  top_val = TOP_F0;
        endcase
    end

    // a count above TOP (live TOP lowered) runs out at all-ones
    assign top_hit = tick && (count == top_val);
    assign wrap    = top_hit || (tick && (count == CNT_ALL1));

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (tick) begin
            count <= wrap ? '0 : count + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_slope_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wrap,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp,
    input  out_mode_e        mode,
    output logic             match,
    output logic             pin
);

    assign match = tick && (count == cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            pin <= 1'b0;
        end else begin
            pin <= pin_next(mode, pin, wrap, match);
        end
    end

endmodule

// File: rtl/pwm_flags.sv
module pwm_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);

    // set beats clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~clr) | set;
        end
    end

endmodule

// File: rtl/pwm_slope_timer.sv
module pwm_slope_timer
    import pwm_slope_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int FIX_W0 = 8,
    parameter int FIX_W1 = 9,
    parameter int FIX_W2 = 10,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              pwm_a,
    output logic              pwm_b,
    output logic              ovf_flag,
    output logic              cmpa_flag,
    output logic              cmpb_flag,
    output logic [CNT_W-1:0]  count
);

    localparam int CH_N = 2;

    ctrl_t              ctrl;
    logic [CNT_W-1:0]   cmpa_act;
    logic [CNT_W-1:0]   cmpb_val;
    logic [CNT_W-1:0]   capt_val;
    logic [CNT_W-1:0]   top_val;
    logic               top_hit;
    logic               wrap;
    logic [FLAG_N-1:0]  flag_clr;
    logic [FLAG_N-1:0]  flag_set;
    logic [FLAG_N-1:0]  flags;
    logic [CNT_W-1:0]   ch_cmp  [CH_N];
    out_mode_e          ch_mode [CH_N];
    logic [CH_N-1:0]    ch_match;
    logic [CH_N-1:0]    ch_pin;
    logic [1:0]         mode_a_w;

    pwm_regs #(
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .top_hit  (top_hit),
        .ctrl     (ctrl),
        .cmpa_act (cmpa_act),
        .cmpb_val (cmpb_val),
        .capt_val (capt_val),
        .flag_clr (flag_clr)
    );

    pwm_counter #(
        .CNT_W  (CNT_W),
        .FIX_W0 (FIX_W0),
        .FIX_W1 (FIX_W1),
        .FIX_W2 (FIX_W2)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_en),
        .top_src  (ctrl.top_src),
        .cmpa_act (cmpa_act),
        .capt_val (capt_val),
        .count    (count),
        .top_val  (top_val),
        .top_hit  (top_hit),
        .wrap     (wrap)
    );

    assign ch_cmp[0]  = cmpa_act;
    assign ch_cmp[1]  = cmpb_val;
    assign ch_mode[0] = ctrl.mode_a;
    assign ch_mode[1] = ctrl.mode_b;

    for (genvar i = 0; i < CH_N; i++) begin : g_ch
        pwm_channel #(
            .CNT_W (CNT_W)
        ) u_ch (
            .clk   (clk),
            .rst   (rst),
            .tick  (tick_en),
            .wrap  (wrap),
            .count (count),
            .cmp   (ch_cmp[i]),
            .mode  (ch_mode[i]),
            .match (ch_match[i]),
            .pin   (ch_pin[i])
        );
    end

    always_comb begin
        flag_set           = '0;
        flag_set[FLG_OVF]  = top_hit;
        flag_set[FLG_CMPA] = ch_match[0];
        flag_set[FLG_CMPB] = ch_match[1];
    end

    pwm_flags #(
        .N (FLAG_N)
    ) u_flags (
        .clk   (clk),
        .rst   (rst),
        .set   (flag_set),
        .clr   (flag_clr),
        .flags (flags)
    );

    assign pwm_a     = ch_pin[0];
    assign pwm_b     = ch_pin[1];
    assign ovf_flag  = flags[FLG_OVF];
    assign cmpa_flag = flags[FLG_CMPA];
    assign cmpb_flag = flags[FLG_CMPB];
    assign mode_a_w  = ctrl.mode_a;

endmodule

// File: rtl/pwm_slope_timer_chk.sv
module pwm_slope_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_en,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] top_val,
    input logic [CNT_W-1:0] cmpa_act,
    input logic [CNT_W-1:0] cmpb_val,
    input logic [1:0]       mode_a,
    input logic             pwm_a,
    input logic             pwm_b,
    input logic             ovf_flag,
    input logic             cmpa_flag,
    input logic             cmpb_flag
);

    localparam logic [CNT_W-1:0] ALL1 = '1;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (count == '0 && !pwm_a && !pwm_b && !ovf_flag && !cmpa_flag && !cmpb_flag));

    p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(count));

    p_step_up_r2: assert property (@(posedge clk) disable iff (rst)
        (tick_en && count != top_val && count != ALL1) |=> (count == $past(count) + 1'b1));

    p_pin_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && mode_a == 2'd1) |=> $stable(pwm_a));

    p_pin_off_r5: assert property (@(posedge clk) disable iff (rst)
        (mode_a == 2'd0) |=> !pwm_a);

    p_shadow_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !(tick_en && count == top_val) |=> $stable(cmpa_act));

    p_runout_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (tick_en && count == ALL1) |=> (count == '0));

    p_top_ovf_r10: assert property (@(posedge clk) disable iff (rst)
        (tick_en && count == top_val) |=> (count == '0 && ovf_flag));

    p_cmpb_flag_r10: assert property (@(posedge clk) disable iff (rst)
        (tick_en && count == cmpb_val) |=> cmpb_flag);

endmodule

bind pwm_slope_timer pwm_slope_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .count     (count),
    .top_val   (top_val),
    .cmpa_act  (cmpa_act),
    .cmpb_val  (cmpb_val),
    .mode_a    (mode_a_w),
    .pwm_a     (pwm_a),
    .pwm_b     (pwm_b),
    .ovf_flag  (ovf_flag),
    .cmpa_flag (cmpa_flag),
    .cmpb_flag (cmpb_flag)
);

// File: tb/pwm_slope_timer_tb.sv
module pwm_slope_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pwm_a, pwm_b, ovf_flag, cmpa_flag, cmpb_flag;
    logic [15:0] count;

    int checks = 0;
    int errors = 0;
    string phase = "R1";

    always #4 clk = ~clk;

    pwm_slope_timer u_dut (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .pwm_a     (pwm_a),
        .pwm_b     (pwm_b),
        .ovf_flag  (ovf_flag),
        .cmpa_flag (cmpa_flag),
        .cmpb_flag (cmpb_flag),
        .count     (count)
    );

    // reference model state, built from the requirements
    logic [15:0] m_cnt, m_sh, m_act, m_b, m_cap;
    logic [2:0]  m_src, m_fl;
    logic [1:0]  m_ma, m_mb;
    logic        m_pa, m_pb;

    function automatic logic [15:0] m_top();
        case (m_src)
            3'd1:    return 16'h01FF;
            3'd2:    return 16'h03FF;
            3'd3:    return m_act;
            3'd4:    return m_cap;
            default: return 16'h00FF;
        endcase
    endfunction

    function automatic logic m_pin(logic [1:0] md, logic cur, logic w, logic mt);
        case (md)
            2'd1:    return w ? 1'b1 : (mt ? 1'b0 : cur);
            2'd2:    return w ? 1'b0 : (mt ? 1'b1 : cur);
            default: return 1'b0;
        endcase
    endfunction

    task automatic model_reset();
        m_cnt = '0; m_sh = '0; m_act = '0; m_b = '0; m_cap = '0;
        m_src = '0; m_fl = '0; m_ma = '0; m_mb = '0; m_pa = 1'b0; m_pb = 1'b0;
    endtask

    task automatic model_step(input logic t, input logic we, input logic [2:0] a, input logic [15:0] d);
        logic [15:0] tp;
        logic hit, wr, ma, mb;
        logic [2:0] clr;
        tp  = m_top();
        hit = t && (m_cnt == tp);
        wr  = hit || (t && m_cnt == 16'hFFFF);
        ma  = t && (m_cnt == m_act);
        mb  = t && (m_cnt == m_b);
        clr = (we && a == 3'd4) ? d[2:0] : 3'b000;
        m_pa = m_pin(m_ma, m_pa, wr, ma);
        m_pb = m_pin(m_mb, m_pb, wr, mb);
        m_fl = (m_fl & ~clr) | {mb, ma, hit};
        if (hit) m_act = m_sh;
        if (t) m_cnt = wr ? 16'h0000 : m_cnt + 16'd1;
        if (we) begin
            case (a)
                3'd0: m_sh  = d;
                3'd1: m_b   = d;
                3'd2: m_cap = d;
                3'd3: begin m_src = d[2:0]; m_ma = d[4:3]; m_mb = d[6:5]; end
                default: ;
            endcase
        end
    endtask

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(input logic t, input logic we, input logic [2:0] a, input logic [15:0] d);
        tick_en = t; wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        model_step(t, we, a, d);
        @(negedge clk);
        tick_en = 1'b0; wr_en = 1'b0;
        checks++;
        if (count !== m_cnt || pwm_a !== m_pa || pwm_b !== m_pb ||
            {cmpb_flag, cmpa_flag, ovf_flag} !== m_fl) begin
            errors++;
            $display("FAIL %s model: actual cnt=%h a=%b b=%b fl=%b expected cnt=%h a=%b b=%b fl=%b",
                     phase, count, pwm_a, pwm_b, {cmpb_flag, cmpa_flag, ovf_flag},
                     m_cnt, m_pa, m_pb, m_fl);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 3'd0, 16'd0);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        cyc(1'b0, 1'b1, a, d);
    endtask

    task automatic meas(input int n, output int ha, output int hb);
        ha = 0; hb = 0;
        for (int i = 0; i < n; i++) begin
            cyc(1'b1, 1'b0, 3'd0, 16'd0);
            ha += int'(pwm_a);
            hb += int'(pwm_b);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R2 watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int ha, hb;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        phase = "R1";
        chk("R1", "count", int'(count), 0);
        chk("R1", "pins", int'({pwm_a, pwm_b}), 0);
        chk("R1", "flags", int'({cmpb_flag, cmpa_flag, ovf_flag}), 0);

        // R2: count only on tick
        phase = "R2";
        ticks(5);
        repeat (6) cyc(1'b0, 1'b0, 3'd0, 16'd0);
        chk("R2", "count held without tick", int'(count), 5);

        // R3 / R10: 8-bit ceiling (reset default)
        phase = "R3";
        ticks(250);
        chk("R3", "count at 8-bit TOP", int'(count), 255);
        chk("R10", "ovf before TOP tick", int'(ovf_flag), 0);
        ticks(1);
        chk("R3", "wrap after 8-bit TOP", int'(count), 0);
        chk("R10", "ovf after TOP tick", int'(ovf_flag), 1);

        // R3: 9-bit and 10-bit ceilings
        wr(3'd3, 16'h0001);
        ticks(511);
        chk("R3", "count at 9-bit TOP", int'(count), 511);
        ticks(1);
        chk("R3", "wrap after 9-bit TOP", int'(count), 0);
        wr(3'd3, 16'h0002);
        ticks(1023);
        chk("R3", "count at 10-bit TOP", int'(count), 1023);
        ticks(1);
        chk("R3", "wrap after 10-bit TOP", int'(count), 0);

        // R4: non-inverting duty on both channels, 8-bit ceiling
        phase = "R4";
        wr(3'd3, 16'h0028);          // src 0, A noninv, B noninv
        wr(3'd1, 16'd99);
        wr(3'd0, 16'd49);
        ticks(256);
        meas(256, ha, hb);
        chk("R4", "pin A high ticks cmp=49", ha, 50);
        chk("R4", "pin B high ticks cmp=99", hb, 100);

        // R5: inverting B, A off
        phase = "R5";
        wr(3'd3, 16'h0040);          // A off, B inverting
        ticks(256);
        meas(256, ha, hb);
        chk("R5", "pin A off", ha, 0);
        chk("R5", "pin B inverted high ticks", hb, 156);

        // R6: zero compare gives one-tick pulse
        phase = "R6";
        wr(3'd3, 16'h0020);
        wr(3'd1, 16'd0);
        ticks(256);
        meas(256, ha, hb);
        chk("R6", "pin B high ticks cmp=0", hb, 1);

        // R7: channel-A compare as TOP
        phase = "R7";
        wr(3'd0, 16'd39);
        ticks(256);                  // shadow loads at TOP
        wr(3'd3, 16'h002B);          // src 3, A noninv, B noninv
        wr(3'd1, 16'd9);
        ticks(39);
        chk("R7", "count at A-as-TOP", int'(count), 39);
        ticks(1);
        chk("R7", "wrap after A-as-TOP", int'(count), 0);
        meas(40, ha, hb);
        chk("R7", "pin A constant high", ha, 40);
        chk("R7", "pin B high ticks", hb, 10);

        // R8: shadow only loads at TOP
        phase = "R8";
        wr(3'd0, 16'd59);
        ticks(39);
        chk("R8", "old TOP still live", int'(count), 39);
        ticks(1);
        chk("R8", "wrap at old TOP", int'(count), 0);
        ticks(59);
        chk("R8", "new TOP live", int'(count), 59);
        ticks(1);
        chk("R8", "wrap at new TOP", int'(count), 0);

        // R9: unbuffered capture lowered below count
        phase = "R9";
        wr(3'd2, 16'd99);
        wr(3'd3, 16'h002C);          // src 4, A noninv, B noninv
        ticks(50);
        wr(3'd2, 16'd20);
        wr(3'd4, 16'h0007);
        ticks(65485);
        chk("R9", "run-out reaches 0xFFFF", int'(count), 65535);
        chk("R10", "no ovf on run-out", int'(ovf_flag), 0);
        ticks(1);
        chk("R9", "wrap from 0xFFFF", int'(count), 0);
        ticks(20);
        chk("R9", "count at capture TOP", int'(count), 20);
        ticks(1);
        chk("R9", "normal period after run-out", int'(count), 0);
        chk("R10", "ovf at capture TOP", int'(ovf_flag), 1);

        // R11: write-1-to-clear, set wins
        phase = "R11";
        wr(3'd4, 16'h0007);
        chk("R11", "all flags cleared", int'({cmpb_flag, cmpa_flag, ovf_flag}), 0);
        ticks(20);
        cyc(1'b1, 1'b1, 3'd4, 16'h0001);
        chk("R11", "set beats clear", int'(ovf_flag), 1);
        wr(3'd4, 16'h0000);
        chk("R11", "zero bits leave flags", int'({cmpb_flag, ovf_flag}), 3);
        wr(3'd4, 16'h0004);
        chk("R11", "clear B only", int'({cmpb_flag, ovf_flag}), 1);

        // random phase: A-as-TOP, random ticks, writes, styles, clears
        phase = "R4";
        wr(3'd3, 16'h002B);
        for (int i = 0; i < 4000; i++) begin
            logic t, we;
            logic [2:0] a;
            logic [15:0] d;
            t  = ($urandom % 4) != 0;
            we = ($urandom % 8) == 0;
            a  = 3'($urandom % 4);
            d  = 16'($urandom % 300);
            if (a == 3'd2) begin
                a = 3'd4;
                d = 16'($urandom % 8);
            end else if (a == 3'd3) begin
                d = {9'd0, 2'($urandom), 2'($urandom), 3'd3};
            end
            cyc(t, we, a, d);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule